// File: doc/BRIEF.md
# 14-bit Programmable Interval Timer

A down counter of 14 bits that advances on a timer input pulse and drives one output pin. The host stages a 16-bit length word that holds a count and an output mode, then issues a 2-bit command to start, stop or retire the timer. The mode selects either a square wave or a single low pulse at terminal count, each of which runs either once or repeatedly.

The count and the active mode can be read back at any time. A terminal-count flag pulses for one clock each time the counter finishes a period. The block sees its bus only as register strobes. Any prescaling of the timer input is done upstream.

Top module: `ptimer14`

## Requirements
- R1: The length word holds the count in bits 13:0 and the mode in bits 15:14. The mode codes are 00 single square wave, 01 continuous square wave, 10 single pulse and 11 continuous pulse. Once a start has taken effect, `cnt_o` and `mode_o` show the loaded count and mode.
- R2: While the timer runs, the count drops by one for each clock in which `tick_i` is high. It holds when `tick_i` is low.
- R3: In the square-wave modes with count length n, the output is high while the count is above n/2 (integer division) and low otherwise. An odd n therefore gives (n+1)/2 high ticks and (n-1)/2 low ticks.
- R4: In the pulse modes the output is low only while the count equals 1, which lasts one timer tick.
- R5: The terminal count is the tick that arrives while the count is 1. In the continuous modes the counter then reloads the count length, and `tc_o` is high for exactly the following clock.
- R6: In the single modes, terminal count stops the timer. The count then reads 0, the output is high and `tc_o` pulses.
- R7: Command 01 stops a running timer in the next clock. The count holds its value, the output goes high, and later ticks are ignored.
- R8: Command 10 lets the running timer finish its current period. At the next terminal count the timer stops, the count reads 0 and the output is high.
- R9: Command 11 given while the timer is idle loads the staged word in the next clock, and counting starts with the following tick.
- R10: Command 11 given while the timer runs takes effect at the next terminal count. The staged word current at that moment is loaded then, and the period in progress is not disturbed. Between a pending start and a pending stop-at-terminal-count, the later command wins.
- R11: A count field below 2 is treated as 2.
- R12: After reset the timer is idle, the output is high and `tc_o` is low. Ticks and command 00 do not start it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer input pulse, one clock wide per count |
| len_we_i | input | 1 | Strobe that stages the length word |
| len_i | input | 16 | Length word: mode in 15:14, count in 13:0 |
| cmd_we_i | input | 1 | Command strobe |
| cmd_i | input | 2 | 00 none, 01 stop now, 10 stop at terminal count, 11 start |
| cnt_o | output | 14 | Current count |
| mode_o | output | 2 | Active mode |
| tmr_o | output | 1 | Timer output pin |
| tc_o | output | 1 | Terminal-count flag, one clock |

## Verification
The assertions check three things on every cycle:
- While the timer runs, the count stays between 1 and the loaded length, and that length is never below 2.
- The count is stable in any cycle with no tick and no command.
- The terminal-count flag never stays high for two clocks. Each terminal count leaves the counter either reloaded or stopped at zero with the output high.

The bench scenarios cover the behaviour that spans a whole period: the split between high and low for odd and even counts, and the single low tick in the pulse modes. They also cover commands that take effect later, namely the deferred start with its new word and the stop at terminal count. Finally they check that the timer does not start on its own after reset.

// File: rtl/ptimer14_pkg.sv
package ptimer14_pkg;
  typedef enum logic [1:0] {
    CMD_NOP     = 2'b00,
    CMD_STOP    = 2'b01,
    CMD_STOP_TC = 2'b10,
    CMD_START   = 2'b11
  } tmr_cmd_e;

  // bit0: repeat, bit1: pulse shape
  typedef enum logic [1:0] {
    MODE_SQ_ONE = 2'b00,
    MODE_SQ_RUN = 2'b01,
    MODE_PL_ONE = 2'b10,
    MODE_PL_RUN = 2'b11
  } tmr_mode_e;
endpackage

// File: rtl/ptimer14_ctrl.sv
module ptimer14_ctrl
  import ptimer14_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       cmd_we_i,
  input  logic [1:0] cmd_i,
  input  logic       at_one_i,
  input  logic       single_i,
  output logic       run_o,
  output logic       load_o,
  output logic       reload_o,
  output logic       dec_o,
  output logic       clear_o,
  output logic       tc_o
);
  logic run_q, run_d;
  logic start_pend_q, start_pend_d;
  logic stop_pend_q, stop_pend_d;
  logic tc_q;
  logic start_req, stop_now, stop_tc_req, tc_ev;
  logic sp_n, st_n;

  assign start_req   = cmd_we_i && (tmr_cmd_e'(cmd_i) == CMD_START);
  assign stop_now    = cmd_we_i && (tmr_cmd_e'(cmd_i) == CMD_STOP);
  assign stop_tc_req = cmd_we_i && (tmr_cmd_e'(cmd_i) == CMD_STOP_TC);

  // later command wins between the two deferred requests
  assign sp_n = stop_tc_req ? 1'b0 : (start_pend_q | start_req);
  assign st_n = start_req   ? 1'b0 : (stop_pend_q  | stop_tc_req);

  assign tc_ev = run_q && tick_i && at_one_i && !stop_now;

  always_comb begin
    load_o       = 1'b0;
    reload_o     = 1'b0;
    dec_o        = 1'b0;
    clear_o      = 1'b0;
    run_d        = run_q;
    start_pend_d = start_pend_q;
    stop_pend_d  = stop_pend_q;
    if (stop_now) begin
      run_d        = 1'b0;
      start_pend_d = 1'b0;
      stop_pend_d  = 1'b0;
    end else if (!run_q) begin
      if (start_req) begin
        load_o = 1'b1;
        run_d  = 1'b1;
      end
      start_pend_d = 1'b0;
      stop_pend_d  = 1'b0;
    end else begin
      start_pend_d = sp_n;
      stop_pend_d  = st_n;
      if (tc_ev) begin
        start_pend_d = 1'b0;
        stop_pend_d  = 1'b0;
        if (sp_n) begin
          load_o = 1'b1;
        end else if (st_n || single_i) begin
          clear_o = 1'b1;
          run_d   = 1'b0;
        end else begin
          reload_o = 1'b1;
        end
      end else if (tick_i) begin
        dec_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q        <= 1'b0;
      start_pend_q <= 1'b0;
      stop_pend_q  <= 1'b0;
      tc_q         <= 1'b0;
    end else begin
      run_q        <= run_d;
      start_pend_q <= start_pend_d;
      stop_pend_q  <= stop_pend_d;
      tc_q         <= tc_ev;
    end
  end

  assign run_o = run_q;
  assign tc_o  = tc_q;

  AST_TC_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_q |=> !tc_q); // R5
  AST_STOP_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cmd_we_i && cmd_i == 2'b01) |-> !run_q); // R7
endmodule

// File: rtl/ptimer14_counter.sv
module ptimer14_counter #(
  parameter int CNT_W  = 14,
  parameter int MODE_W = 2,
  localparam int WORD_W = CNT_W + MODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              load_i,
  input  logic              reload_i,
  input  logic              dec_i,
  input  logic              clear_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  len_o,
  output logic [MODE_W-1:0] mode_o
);
  localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(2);

  logic [CNT_W-1:0]  cnt_q, len_q, new_len;
  logic [MODE_W-1:0] mode_q;

  assign new_len = (word_i[CNT_W-1:0] < MIN_LEN) ? MIN_LEN : word_i[CNT_W-1:0];

  // datapath carries no reset: reset only halts the timer
  always_ff @(posedge clk_i) begin
    if (load_i) begin
      cnt_q  <= new_len;
      len_q  <= new_len;
      mode_q <= word_i[WORD_W-1:CNT_W];
    end else if (reload_i) begin
      cnt_q <= len_q;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (dec_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign len_o  = len_q;
  assign mode_o = mode_q;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q != '0) && (cnt_q <= len_q)); // R2
  AST_LEN_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> len_q >= MIN_LEN); // R11
endmodule

// File: rtl/ptimer14_wave.sv
module ptimer14_wave #(
  parameter int CNT_W = 14
) (
  input  logic             run_i,
  input  logic             pulse_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             tmr_o
);
  logic [CNT_W-1:0] half;
  logic             sq_hi, pl_hi;

  assign half  = len_i >> 1;
  assign sq_hi = cnt_i > half;
  assign pl_hi = cnt_i != CNT_W'(1);

  always_comb begin
    if (!run_i)       tmr_o = 1'b1;
    else if (pulse_i) tmr_o = pl_hi;
    else              tmr_o = sq_hi;
  end
endmodule

// File: rtl/ptimer14.sv
module ptimer14
  import ptimer14_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter int MODE_W = 2,
  localparam int WORD_W = CNT_W + MODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              len_we_i,
  input  logic [WORD_W-1:0] len_i,
  input  logic              cmd_we_i,
  input  logic [1:0]        cmd_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              tmr_o,
  output logic              tc_o
);
  logic [WORD_W-1:0] stage_q;
  logic [CNT_W-1:0]  len;
  logic run, load, reload, dec, clear, at_one;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       stage_q <= '0;
    else if (len_we_i) stage_q <= len_i;
  end

  assign at_one = cnt_o == CNT_W'(1);

  ptimer14_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .cmd_we_i (cmd_we_i),
    .cmd_i    (cmd_i),
    .at_one_i (at_one),
    .single_i (!mode_o[0]),
    .run_o    (run),
    .load_o   (load),
    .reload_o (reload),
    .dec_o    (dec),
    .clear_o  (clear),
    .tc_o     (tc_o)
  );

  ptimer14_counter #(.CNT_W(CNT_W), .MODE_W(MODE_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .load_i   (load),
    .reload_i (reload),
    .dec_i    (dec),
    .clear_i  (clear),
    .word_i   (stage_q),
    .cnt_o    (cnt_o),
    .len_o    (len),
    .mode_o   (mode_o)
  );

  ptimer14_wave #(.CNT_W(CNT_W)) u_wave (
    .run_i   (run),
    .pulse_i (mode_o[1]),
    .cnt_i   (cnt_o),
    .len_i   (len),
    .tmr_o   (tmr_o)
  );

  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cmd_we_i && cmd_i == 2'b11 && !run) |-> run && (cnt_o == len)); // R9
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && $past(run && !tick_i && !cmd_we_i) |-> $stable(cnt_o)); // R2
  AST_TC_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o && run |-> cnt_o == len); // R5
  AST_SINGLE_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o && !run |-> (cnt_o == '0) && tmr_o); // R6
  AST_SQ_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o && run && !mode_o[1] |-> tmr_o); // R3
endmodule

// File: tb/tb_ptimer14.sv
`timescale 1ns/1ps
module tb_ptimer14;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        len_we = 1'b0;
  logic [15:0] len_d = '0;
  logic        cmd_we = 1'b0;
  logic [1:0]  cmd = 2'b00;
  logic [13:0] cnt;
  logic [1:0]  mode;
  logic        tmr, tc;

  localparam logic [1:0] C_NOP = 2'b00, C_STOP = 2'b01, C_STC = 2'b10, C_GO = 2'b11;

  always #2.5 clk = ~clk;

  ptimer14 dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .len_we_i(len_we), .len_i(len_d),
    .cmd_we_i(cmd_we), .cmd_i(cmd), .cnt_o(cnt), .mode_o(mode), .tmr_o(tmr), .tc_o(tc)
  );

  typedef struct {
    int    due;
    string req;
    bit    tmr;
    bit    tc;
    bit    chk_cnt;
    int    cnt;
    bit    chk_mode;
    int    mode;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  always @(posedge clk) cyc++;

  // monitor: compare every item whose cycle has come
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      e = q.pop_front();
      checks++;
      if (tmr !== e.tmr || tc !== e.tc ||
          (e.chk_cnt && cnt !== 14'(e.cnt)) || (e.chk_mode && mode !== 2'(e.mode))) begin
        errors++;
        $display("FAIL %s cyc %0d: tmr=%0b tc=%0b cnt=%0d mode=%0d expected tmr=%0b tc=%0b cnt=%0d mode=%0d",
                 e.req, cyc, tmr, tc, cnt, mode, e.tmr, e.tc, e.cnt, e.mode);
      end
    end
  end

  function automatic bit sq(int c, int n);
    return c > n / 2;
  endfunction

  // driver: apply one clock of stimulus and queue what it must produce
  task automatic step(bit tk, bit cwe, logic [1:0] c, string req, bit et, bit etc,
                      bit cc, int ec, bit cm = 0, int em = 0);
    exp_t it;
    tick = tk; cmd_we = cwe; cmd = c;
    it.due = cyc + 1; it.req = req; it.tmr = et; it.tc = etc;
    it.chk_cnt = cc; it.cnt = ec; it.chk_mode = cm; it.mode = em;
    q.push_back(it);
    @(negedge clk);
    tick = 0; cmd_we = 0; cmd = C_NOP;
  endtask

  task automatic wr_len(logic [15:0] w);
    len_we = 1; len_d = w;
    @(negedge clk);
    len_we = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12: idle after reset, ticks and NOP do nothing
    step(0, 0, C_NOP, "R12", 1, 0, 0, 0);
    step(1, 0, C_NOP, "R12", 1, 0, 0, 0);
    step(1, 1, C_NOP, "R12", 1, 0, 0, 0);
    step(1, 1, C_STOP, "R12", 1, 0, 0, 0);

    // single square, n=5
    wr_len(16'h0005);
    step(0, 1, C_GO, "R1 R9", 1, 0, 1, 5, 1, 0);
    step(0, 0, C_NOP, "R2", 1, 0, 1, 5);
    for (int k = 1; k < 5; k++) step(1, 0, C_NOP, "R3", sq(5 - k, 5), 0, 1, 5 - k);
    step(1, 0, C_NOP, "R6", 1, 1, 1, 0);
    step(0, 0, C_NOP, "R6", 1, 0, 1, 0);
    step(1, 0, C_NOP, "R6", 1, 0, 1, 0);

    // continuous square, n=9
    wr_len(16'h4009);
    step(0, 1, C_GO, "R1", 1, 0, 1, 9, 1, 1);
    for (int p = 0; p < 2; p++) begin
      for (int k = 1; k < 9; k++) step(1, 0, C_NOP, "R3", sq(9 - k, 9), 0, 1, 9 - k);
      step(1, 0, C_NOP, "R5", 1, 1, 1, 9);
    end
    step(1, 0, C_NOP, "R2", 1, 0, 1, 8);
    step(0, 1, C_STC, "R8", 1, 0, 1, 8);
    for (int k = 2; k < 9; k++) step(1, 0, C_NOP, "R8", sq(9 - k, 9), 0, 1, 9 - k);
    step(1, 0, C_NOP, "R8", 1, 1, 1, 0);
    step(1, 0, C_NOP, "R8", 1, 0, 1, 0);

    // single pulse, n=3
    wr_len(16'h8003);
    step(0, 1, C_GO, "R1", 1, 0, 1, 3, 1, 2);
    step(1, 0, C_NOP, "R4", 1, 0, 1, 2);
    step(1, 0, C_NOP, "R4", 0, 0, 1, 1);
    step(1, 0, C_NOP, "R6", 1, 1, 1, 0);

    // continuous pulse, n=4
    wr_len(16'hC004);
    step(0, 1, C_GO, "R1", 1, 0, 1, 4, 1, 3);
    for (int p = 0; p < 2; p++) begin
      step(1, 0, C_NOP, "R4", 1, 0, 1, 3);
      step(1, 0, C_NOP, "R4", 1, 0, 1, 2);
      step(1, 0, C_NOP, "R4", 0, 0, 1, 1);
      step(1, 0, C_NOP, "R5", 1, 1, 1, 4);
    end
    step(1, 0, C_NOP, "R2", 1, 0, 1, 3);
    step(1, 0, C_NOP, "R2", 1, 0, 1, 2);
    step(0, 1, C_STOP, "R7", 1, 0, 1, 2);
    step(1, 0, C_NOP, "R7", 1, 0, 1, 2);
    step(1, 0, C_NOP, "R7", 1, 0, 1, 2);

    // short counts
    wr_len(16'h0001);
    step(0, 1, C_GO, "R11", 1, 0, 1, 2);
    step(1, 0, C_NOP, "R11", 0, 0, 1, 1);
    step(1, 0, C_NOP, "R11", 1, 1, 1, 0);
    wr_len(16'h4000);
    step(0, 1, C_GO, "R11", 1, 0, 1, 2);
    step(1, 0, C_NOP, "R11", 0, 0, 1, 1);
    step(1, 0, C_NOP, "R11", 1, 1, 1, 2);
    step(0, 1, C_STOP, "R11", 1, 0, 1, 2);

    // start while running is deferred to terminal count
    wr_len(16'h4006);
    step(0, 1, C_GO, "R9", 1, 0, 1, 6, 1, 1);
    step(1, 0, C_NOP, "R10", 1, 0, 1, 5);
    step(1, 0, C_NOP, "R10", 1, 0, 1, 4);
    wr_len(16'hC003);
    step(0, 0, C_NOP, "R10", 1, 0, 1, 4, 1, 1);
    step(0, 1, C_GO, "R10", 1, 0, 1, 4, 1, 1);
    step(1, 0, C_NOP, "R10", 0, 0, 1, 3, 1, 1);
    step(1, 0, C_NOP, "R10", 0, 0, 1, 2);
    step(1, 0, C_NOP, "R10", 0, 0, 1, 1);
    step(1, 0, C_NOP, "R10", 1, 1, 1, 3, 1, 3);
    step(1, 0, C_NOP, "R10", 1, 0, 1, 2);
    step(1, 0, C_NOP, "R10", 0, 0, 1, 1);
    step(1, 0, C_NOP, "R10", 1, 1, 1, 3);
    // later command wins: start then stop-at-tc stops
    step(0, 1, C_GO, "R10", 1, 0, 1, 3);
    step(0, 1, C_STC, "R10", 1, 0, 1, 3);
    step(1, 0, C_NOP, "R10", 1, 0, 1, 2);
    step(1, 0, C_NOP, "R10", 0, 0, 1, 1);
    step(1, 0, C_NOP, "R10", 1, 1, 1, 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R12: actual run still busy, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule